// File: doc/BRIEF.md
# Indexed Control Register Port

This block is the host-facing front end of a real-time clock. The host sees two addresses. With address bit 0 low, a write loads a 7-bit pointer and a read returns all ones. With address bit 0 high, the access goes to the byte the pointer selects in a 128-byte space. The block holds the four control registers, which sit at pointer values 10 to 13. It owns the interrupt flag register and the interrupt line. It presents the decoded control fields to the timekeeping and periodic-rate logic. The bytes above the control registers are plain scratch storage.

The low pointer values hold the time and date. These bytes are not stored here. Writes to them go out as a strobe with pointer and data to a separate calendar block. Reads of them return the byte that the calendar block supplies for the current pointer. The timekeeping logic reports the start and end of each one-second update, and it raises single-cycle event pulses for the periodic tick, the alarm match and the end of an update. The block folds these pulses into its flag register. Reading the flag register both reports the flags and clears them.

Top module: `idx_reg_port`

## Requirements
- R1: A write with `bus_addr0` low loads the pointer from `bus_wdata[6:0]`. Bit 7 of the data is ignored. A later data access uses that pointer, and `cal_idx` shows it.
- R2: A read with `bus_addr0` low returns 0xFF on `bus_rdata`.
- R3: In control byte A (pointer 10), host writes set bits 6:0, with `osc_sel` = bits 6:4 and `rate_sel` = bits 3:0. Bit 7 (update busy) is read-only to the host.
- R4: Host writes to the flag byte (pointer 12) and to the status byte (pointer 13) change nothing. The status byte always reads 0x80.
- R5: A read of the flag byte returns its current value. At the following clock edge it clears the byte to zero and drops `irq`, except for flags that arrive in that same cycle.
- R6: Writing control byte B (pointer 11) with bit 7 set stores bit 4 as 0 and clears the update-busy bit in byte A.
- R7: Control byte B drives the outputs at these bit positions: 7 `set_mode`, 6 `per_en`, 5 `alarm_en`, 4 `upd_en`, 3 `sqw_en`, 2 `bin_mode`, 1 `h24_mode`.
- R8: The `evt_periodic`, `evt_alarm` and `evt_update` pulses set flag bits 6, 5 and 4. If the matching enable in byte B (bit 6, 5 or 4) is set at that moment, the pulse also sets flag bit 7. `irq` always equals flag bit 7.
- R9: If a flag pulse lands in the same cycle as a flag-byte read, the read returns the old value and the new flag is kept.
- R10: After `rst_n`, bytes A, B, C and D read 0x26, 0x02, 0x00 and 0x80.
- R11: While `bus_rst` is high, host accesses have no effect. At the edge it clears bits 6, 5 and 3 of byte B and every flag, and it leaves the other bits of B unchanged.
- R12: A data write to a pointer below TIME_REGS raises `cal_wr` for that cycle, with `cal_wdata` equal to the data. A data read there returns `cal_rdata`.
- R13: Pointers 14 to 127 store the bytes written to them and read them back.
- R14: `upd_begin` sets the update-busy bit only while `set_mode` is low. `upd_end` clears it. `upd_busy` mirrors it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_rst | input | 1 | Synchronous bus reset |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr0 | input | 1 | 0 = pointer port, 1 = data port |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (combinational) |
| cal_idx | output | IDX_W | Current pointer |
| cal_wr | output | 1 | Write strobe for time bytes |
| cal_wdata | output | 8 | Write data for time bytes |
| cal_rdata | input | 8 | Time byte at `cal_idx` |
| upd_begin | input | 1 | One-second update started |
| upd_end | input | 1 | One-second update finished |
| evt_periodic | input | 1 | Periodic tick pulse |
| evt_alarm | input | 1 | Alarm match pulse |
| evt_update | input | 1 | Update-ended pulse |
| osc_sel | output | 3 | Byte A bits 6:4 |
| rate_sel | output | 4 | Byte A bits 3:0 |
| upd_busy | output | 1 | Byte A bit 7 |
| set_mode | output | 1 | Byte B bit 7 |
| per_en | output | 1 | Byte B bit 6 |
| alarm_en | output | 1 | Byte B bit 5 |
| upd_en | output | 1 | Byte B bit 4 |
| sqw_en | output | 1 | Byte B bit 3 |
| bin_mode | output | 1 | Byte B bit 2 |
| h24_mode | output | 1 | Byte B bit 1 |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench builds the block with its defaults: a 7-bit pointer, ten time bytes and spare storage enabled. The full 128-byte map is therefore reachable, including the boundaries between the time bytes, the control bytes and the storage from pointer 14 upward. Random pointers are weighted toward 0 to 15 so that the control-byte side effects come up often. Event pulses, update pulses and flag reads are mixed freely, which makes same-cycle collisions between flag reads and flag pulses a regular occurrence. Directed sequences cover the reset values, the pointer with bit 7 set, entering set mode, and a bus reset.

// File: rtl/irp_pkg.sv
package irp_pkg;
   localparam int unsigned DW = 8;

   localparam int unsigned IDX_A = 10;
   localparam int unsigned IDX_B = 11;
   localparam int unsigned IDX_C = 12;
   localparam int unsigned IDX_D = 13;

   localparam int unsigned A_BUSY = 7;
   localparam int unsigned B_SET  = 7;
   localparam int unsigned B_PER  = 6;
   localparam int unsigned B_ALM  = 5;
   localparam int unsigned B_UPD  = 4;
   localparam int unsigned B_SQW  = 3;
   localparam int unsigned B_BIN  = 2;
   localparam int unsigned B_H24  = 1;
   localparam int unsigned C_IRQ  = 7;
   localparam int unsigned C_PER  = 6;
   localparam int unsigned C_ALM  = 5;
   localparam int unsigned C_UPD  = 4;

   localparam logic [DW-1:0] RST_A = 8'h26;
   localparam logic [DW-1:0] RST_B = 8'h02;
   localparam logic [DW-1:0] RST_C = 8'h00;
   localparam logic [DW-1:0] VAL_D = 8'h80;
   localparam logic [DW-1:0] BUSRST_B_MASK = 8'h68;

   typedef enum logic [1:0] {
      ACC_NONE    = 2'd0,
      ACC_PTR_WR  = 2'd1,
      ACC_DATA_WR = 2'd2,
      ACC_DATA_RD = 2'd3
   } acc_e;

   typedef struct packed {
      logic per;
      logic alm;
      logic upd;
   } evt_t;
endpackage

// File: rtl/irp_index_reg.sv
module irp_index_reg
   import irp_pkg::*;
#(
   parameter int unsigned IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hold,
   input  logic             sel,
   input  logic             wr,
   input  logic             addr0,
   input  logic [DW-1:0]    wdata,
   output logic [IDX_W-1:0] idx,
   output acc_e             acc
);
   always_comb begin
      acc = ACC_NONE;
      if (sel && !hold) begin
         if (!addr0) acc = wr ? ACC_PTR_WR : ACC_NONE;
         else        acc = wr ? ACC_DATA_WR : ACC_DATA_RD;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  idx <= '0;
      else if (acc == ACC_PTR_WR)  idx <= wdata[IDX_W-1:0];
   end
endmodule

// File: rtl/irp_byte_store.sv
module irp_byte_store
   import irp_pkg::*;
#(
   parameter int unsigned IDX_W    = 7,
   parameter bit          SPARE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] addr,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   generate
      if (SPARE_EN) begin : g_mem
         logic [DW-1:0] mem [DEPTH];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[addr] <= wdata;
            end
         end
         assign rdata = mem[addr];
      end else begin : g_none
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, we, addr, wdata};
         assign rdata = '0;
      end
   endgenerate
endmodule

// File: rtl/irp_ctrl_regs.sv
module irp_ctrl_regs
   import irp_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_rst,
   input  logic          wr_a,
   input  logic          wr_b,
   input  logic          rd_c,
   input  logic [DW-1:0] wdata,
   input  logic          upd_begin,
   input  logic          upd_end,
   input  evt_t          evt,
   output logic [DW-1:0] reg_a,
   output logic [DW-1:0] reg_b,
   output logic [DW-1:0] reg_c
);
   logic [DW-1:0] a_n, b_n, c_n;
   logic          enter_set, busy_n, cause;
   logic [DW-1:0] c_base, c_new;

   assign enter_set = wr_b && wdata[B_SET];

   always_comb begin
      if (enter_set)                       busy_n = 1'b0;
      else if (upd_end)                    busy_n = 1'b0;
      else if (upd_begin && !reg_b[B_SET]) busy_n = 1'b1;
      else                                 busy_n = reg_a[A_BUSY];
   end

   always_comb begin
      a_n = reg_a;
      if (wr_a) a_n[A_BUSY-1:0] = wdata[A_BUSY-1:0];
      a_n[A_BUSY] = busy_n;
   end

   always_comb begin
      b_n = reg_b;
      if (wr_b) begin
         b_n = wdata;
         if (wdata[B_SET]) b_n[B_UPD] = 1'b0;
      end
      if (bus_rst) b_n = reg_b & ~BUSRST_B_MASK;
   end

   always_comb begin
      cause = (evt.per && reg_b[B_PER]) ||
              (evt.alm && reg_b[B_ALM]) ||
              (evt.upd && reg_b[B_UPD]);
      c_new = '0;
      c_new[C_PER] = evt.per;
      c_new[C_ALM] = evt.alm;
      c_new[C_UPD] = evt.upd;
      c_new[C_IRQ] = cause;
      c_base = rd_c ? '0 : reg_c;
      c_n = bus_rst ? '0 : (c_base | c_new);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_a <= RST_A;
         reg_b <= RST_B;
         reg_c <= RST_C;
      end else begin
         reg_a <= a_n;
         reg_b <= b_n;
         reg_c <= c_n;
      end
   end
endmodule

// File: rtl/idx_reg_port.sv
module idx_reg_port
   import irp_pkg::*;
#(
   parameter int unsigned IDX_W     = 7,
   parameter int unsigned TIME_REGS = 10,
   parameter bit          SPARE_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_rst,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic             bus_addr0,
   input  logic [7:0]       bus_wdata,
   output logic [7:0]       bus_rdata,
   output logic [IDX_W-1:0] cal_idx,
   output logic             cal_wr,
   output logic [7:0]       cal_wdata,
   input  logic [7:0]       cal_rdata,
   input  logic             upd_begin,
   input  logic             upd_end,
   input  logic             evt_periodic,
   input  logic             evt_alarm,
   input  logic             evt_update,
   output logic [2:0]       osc_sel,
   output logic [3:0]       rate_sel,
   output logic             upd_busy,
   output logic             set_mode,
   output logic             per_en,
   output logic             alarm_en,
   output logic             upd_en,
   output logic             sqw_en,
   output logic             bin_mode,
   output logic             h24_mode,
   output logic             irq
);
   localparam logic [IDX_W-1:0] P_A    = IDX_W'(IDX_A);
   localparam logic [IDX_W-1:0] P_B    = IDX_W'(IDX_B);
   localparam logic [IDX_W-1:0] P_C    = IDX_W'(IDX_C);
   localparam logic [IDX_W-1:0] P_D    = IDX_W'(IDX_D);
   localparam logic [IDX_W-1:0] P_TIME = IDX_W'(TIME_REGS);

   generate
      if (IDX_W < 4 || IDX_W > 7) begin : g_bad_idx
         $error("IDX_W must lie in 4..7");
      end
      if (TIME_REGS < 1 || TIME_REGS > IDX_A) begin : g_bad_time
         $error("TIME_REGS must lie in 1..10");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   acc_e             acc;
   logic             data_wr, data_rd, in_time, in_ctrl;
   logic [DW-1:0]    reg_a, reg_b, reg_c, store_rd;
   evt_t             evt;

   irp_index_reg #(.IDX_W(IDX_W)) u_index (
      .clk(clk), .rst_n(rst_n), .hold(bus_rst), .sel(bus_sel), .wr(bus_wr),
      .addr0(bus_addr0), .wdata(bus_wdata), .idx(idx), .acc(acc)
   );

   assign data_wr = (acc == ACC_DATA_WR);
   assign data_rd = (acc == ACC_DATA_RD);
   assign in_time = (idx < P_TIME);
   assign in_ctrl = (idx >= P_A) && (idx <= P_D);
   assign evt     = '{per: evt_periodic, alm: evt_alarm, upd: evt_update};

   irp_ctrl_regs u_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst),
      .wr_a(data_wr && idx == P_A), .wr_b(data_wr && idx == P_B),
      .rd_c(data_rd && idx == P_C), .wdata(bus_wdata),
      .upd_begin(upd_begin), .upd_end(upd_end), .evt(evt),
      .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c)
   );

   irp_byte_store #(.IDX_W(IDX_W), .SPARE_EN(SPARE_EN)) u_store (
      .clk(clk), .rst_n(rst_n), .we(data_wr && !in_time && !in_ctrl),
      .addr(idx), .wdata(bus_wdata), .rdata(store_rd)
   );

   always_comb begin
      if (!bus_addr0)      bus_rdata = 8'hFF;
      else if (in_time)    bus_rdata = cal_rdata;
      else if (idx == P_A) bus_rdata = reg_a;
      else if (idx == P_B) bus_rdata = reg_b;
      else if (idx == P_C) bus_rdata = reg_c;
      else if (idx == P_D) bus_rdata = VAL_D;
      else                 bus_rdata = store_rd;
   end

   assign cal_idx   = idx;
   assign cal_wr    = data_wr && in_time;
   assign cal_wdata = bus_wdata;

   assign osc_sel  = reg_a[6:4];
   assign rate_sel = reg_a[3:0];
   assign upd_busy = reg_a[A_BUSY];
   assign set_mode = reg_b[B_SET];
   assign per_en   = reg_b[B_PER];
   assign alarm_en = reg_b[B_ALM];
   assign upd_en   = reg_b[B_UPD];
   assign sqw_en   = reg_b[B_SQW];
   assign bin_mode = reg_b[B_BIN];
   assign h24_mode = reg_b[B_H24];
   assign irq      = reg_c[C_IRQ];
endmodule

// File: rtl/idx_reg_port_chk.sv
module idx_reg_port_chk #(
   parameter int unsigned IDX_W     = 7,
   parameter int unsigned TIME_REGS = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_rst,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic             bus_addr0,
   input logic [7:0]       bus_wdata,
   input logic [7:0]       bus_rdata,
   input logic [IDX_W-1:0] cal_idx,
   input logic             cal_wr,
   input logic             evt_periodic,
   input logic             evt_alarm,
   input logic             evt_update,
   input logic             upd_busy,
   input logic             set_mode,
   input logic             per_en,
   input logic             alarm_en,
   input logic             upd_en,
   input logic             sqw_en,
   input logic             irq
);
   localparam logic [IDX_W-1:0] P_B    = IDX_W'(11);
   localparam logic [IDX_W-1:0] P_C    = IDX_W'(12);
   localparam logic [IDX_W-1:0] P_D    = IDX_W'(13);
   localparam logic [IDX_W-1:0] P_TIME = IDX_W'(TIME_REGS);

   logic no_evt, dwr, drd;
   assign no_evt = !evt_periodic && !evt_alarm && !evt_update;
   assign dwr    = bus_sel && bus_wr && bus_addr0 && !bus_rst;
   assign drd    = bus_sel && !bus_wr && bus_addr0 && !bus_rst;

   assert_ptr_read_ff_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && !bus_addr0) |-> bus_rdata == 8'hFF);

   assert_flag_wr_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dwr && (cal_idx == P_C || cal_idx == P_D) && !irq && no_evt) |=> !irq);

   assert_flag_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (drd && cal_idx == P_C && no_evt) |=> !irq);

   assert_set_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dwr && cal_idx == P_B && bus_wdata[7]) |=> (set_mode && !upd_en && !upd_busy));

   assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past((per_en && evt_periodic) || (alarm_en && evt_alarm) ||
                           (upd_en && evt_update)));

   assert_bus_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> (!irq && !per_en && !alarm_en && !sqw_en));

   assert_cal_wr_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cal_wr |-> (cal_idx < P_TIME && bus_wr && bus_addr0));

   assert_busy_not_in_set_R14: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(upd_busy) |-> $past(!set_mode));
endmodule

bind idx_reg_port idx_reg_port_chk #(.IDX_W(IDX_W), .TIME_REGS(TIME_REGS)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr0(bus_addr0), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .cal_idx(cal_idx), .cal_wr(cal_wr), .evt_periodic(evt_periodic),
   .evt_alarm(evt_alarm), .evt_update(evt_update), .upd_busy(upd_busy),
   .set_mode(set_mode), .per_en(per_en), .alarm_en(alarm_en), .upd_en(upd_en),
   .sqw_en(sqw_en), .irq(irq)
);

// File: tb/idx_reg_port_tb.sv
`timescale 1ns/1ps
module idx_reg_port_tb;
   logic       clk = 1'b0, rst_n = 1'b0, bus_rst = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_addr0 = 1'b0;
   logic [7:0] bus_wdata = '0, bus_rdata, cal_wdata, cal_rdata;
   logic [6:0] cal_idx;
   logic       cal_wr, upd_begin = 1'b0, upd_end = 1'b0;
   logic       evt_periodic = 1'b0, evt_alarm = 1'b0, evt_update = 1'b0;
   logic [2:0] osc_sel;
   logic [3:0] rate_sel;
   logic       upd_busy, set_mode, per_en, alarm_en, upd_en, sqw_en, bin_mode, h24_mode, irq;

   int n_cmp = 0, n_bad = 0;
   bit done = 1'b0;

   // model state
   logic [6:0] m_idx = '0;
   logic [7:0] m_a = 8'h26, m_b = 8'h02, m_c = 8'h00;
   logic [7:0] m_mem [128];

   always #2 clk = ~clk;
   assign cal_rdata = {1'b0, cal_idx} ^ 8'h5A;

   idx_reg_port u_dut (.*);

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   function automatic logic [7:0] exp_rd(input logic a0);
      if (!a0)               return 8'hFF;
      else if (m_idx < 10)   return {1'b0, m_idx} ^ 8'h5A;
      else if (m_idx == 10)  return m_a;
      else if (m_idx == 11)  return m_b;
      else if (m_idx == 12)  return m_c;
      else if (m_idx == 13)  return 8'h80;
      else                   return m_mem[m_idx];
   endfunction

   function automatic string auto_tag(input logic a0);
      if (!a0)               return "R2";
      else if (m_idx < 10)   return "R12";
      else if (m_idx == 10)  return "R3";
      else if (m_idx == 11)  return "R7";
      else if (m_idx == 12)  return "R5";
      else if (m_idx == 13)  return "R4";
      else                   return "R13";
   endfunction

   task automatic check_outputs();
      check("R8 irq", irq, m_c[7]);
      check("R7 B fields", {set_mode, per_en, alarm_en, upd_en, sqw_en, bin_mode, h24_mode},
            m_b[7:1]);
      check("R14 busy", upd_busy, m_a[7]);
      check("R3 A fields", {osc_sel, rate_sel}, m_a[6:0]);
      check("R1 pointer", cal_idx, m_idx);
   endtask

   task automatic step(input bit sel, input bit wr, input bit a0, input logic [7:0] wd,
                       input bit pf, input bit af, input bit uf, input bit ub, input bit ue,
                       input bit br, input string tag);
      bit dw, rc, bset;
      logic [7:0] nb, nc;
      @(negedge clk);
      check_outputs();
      bus_sel = sel; bus_wr = wr; bus_addr0 = a0; bus_wdata = wd;
      evt_periodic = pf; evt_alarm = af; evt_update = uf;
      upd_begin = ub; upd_end = ue; bus_rst = br;
      #1;
      if (sel && !wr) check(tag == "" ? auto_tag(a0) : tag, bus_rdata, exp_rd(a0));
      dw = sel && wr && a0 && !br;
      check("R12 cal_wr", cal_wr, dw && (m_idx < 10));
      if (dw && m_idx < 10) check("R12 cal_wdata", cal_wdata, wd);
      @(posedge clk);
      rc   = sel && !wr && a0 && !br && (m_idx == 12);
      bset = dw && (m_idx == 11) && wd[7];
      nc = br ? 8'h00 : ((rc ? 8'h00 : m_c) |
           {(pf && m_b[6]) || (af && m_b[5]) || (uf && m_b[4]), pf, af, uf, 4'h0});
      nb = m_b;
      if (dw && m_idx == 11) nb = wd[7] ? (wd & 8'hEF) : wd;
      if (br) nb = m_b & ~8'h68;
      if (bset)                  m_a[7] = 1'b0;
      else if (ue)               m_a[7] = 1'b0;
      else if (ub && !m_b[7])    m_a[7] = 1'b1;
      if (dw && m_idx == 10) m_a[6:0] = wd[6:0];
      if (dw && m_idx >= 14) m_mem[m_idx] = wd;
      m_b = nb; m_c = nc;
      if (sel && wr && !a0 && !br) m_idx = wd[6:0];
   endtask

   task automatic ptr(input logic [7:0] v);
      step(1, 1, 0, v, 0, 0, 0, 0, 0, 0, "R1");
   endtask
   task automatic rd(input string tag);
      step(1, 0, 1, 8'h00, 0, 0, 0, 0, 0, 0, tag);
   endtask
   task automatic wrd(input logic [7:0] v);
      step(1, 1, 1, v, 0, 0, 0, 0, 0, 0, "");
   endtask
   task automatic idle();
      step(0, 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "");
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd2024);
      for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R10 reset values
      ptr(8'd10); rd("R10 A");
      ptr(8'd11); rd("R10 B");
      ptr(8'd12); rd("R10 C");
      ptr(8'd13); rd("R10 D");
      step(1, 0, 0, 8'h00, 0, 0, 0, 0, 0, 0, "R2 ptr read");

      // R1 pointer ignores bit 7
      ptr(8'h8E); wrd(8'hC3); ptr(8'h0E); rd("R1 high bit");
      // R13 top of space
      ptr(8'h7F); wrd(8'h3C); rd("R13 last byte");
      // R3 busy bit read-only
      step(0, 0, 0, 8'h00, 0, 0, 0, 1, 0, 0, "");
      ptr(8'd10); wrd(8'h00); rd("R3 busy kept");
      step(0, 0, 0, 8'h00, 0, 0, 0, 0, 1, 0, "");
      wrd(8'hFF); rd("R3 busy not written");
      // R4 writes ignored
      ptr(8'd12); wrd(8'hFF); rd("R4 C write");
      ptr(8'd13); wrd(8'h00); rd("R4 D write");
      // R8 enables: periodic enabled only
      ptr(8'd11); wrd(8'h42);
      step(0, 0, 0, 8'h00, 1, 1, 0, 0, 0, 0, "");
      ptr(8'd12); idle(); rd("R5 flags with irq"); idle(); rd("R5 cleared");
      // R9 collision
      step(0, 0, 0, 8'h00, 0, 0, 1, 0, 0, 0, "");
      step(1, 0, 1, 8'h00, 0, 1, 0, 0, 0, 0, "R9 old value");
      rd("R9 new flag kept");
      // R6 set mode entry
      step(0, 0, 0, 8'h00, 0, 0, 0, 1, 0, 0, "");
      ptr(8'd11); wrd(8'hFF); rd("R6 upd enable forced low");
      ptr(8'd10); rd("R6 busy cleared");
      step(0, 0, 0, 8'h00, 0, 0, 0, 1, 0, 0, "");
      rd("R14 busy blocked in set mode");
      // R11 bus reset
      ptr(8'd11); wrd(8'h7E);
      step(0, 0, 0, 8'h00, 1, 1, 1, 0, 0, 0, "");
      step(1, 1, 1, 8'hFF, 0, 0, 0, 0, 0, 1, "");
      rd("R11 B after bus reset");
      ptr(8'd12); rd("R11 C after bus reset");
      // R12 time bytes
      ptr(8'd3); wrd(8'h59); rd("R12 time read");

      // random phase
      for (int n = 0; n < 600; n++) begin
         int unsigned op;
         logic [7:0] v;
         op = $urandom_range(0, 9);
         v  = 8'($urandom);
         if (op < 3) begin
            if ($urandom_range(0, 3) != 0) v = {v[7], 3'b000, v[3:0]};
            step(1, 1, 0, v, 0, 0, 0, 0, 0, 0, "R1");
         end else begin
            step(op != 9, op < 5, op != 8, v,
                 $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
                 $urandom_range(0, 9) == 0, $urandom_range(0, 15) == 0,
                 $urandom_range(0, 15) == 0, $urandom_range(0, 63) == 0, "");
         end
      end
      idle();
      idle();

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule